// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data between memory and I/O space on a 16-bit embedded bus without processor involvement. It holds two independent channels. Each has a 20-bit source pointer, a 20-bit destination pointer, a transfer counter and a control word. Software sets these up through a small register port. Every transfer is made of two bus cycles on a single-request master handshake. The first is a fetch that reads from the source. The second is a deposit that writes to the destination. Each channel can run in byte or word width, and each of its two pointers can step up, step down or stay put.

A channel starts its transfers once it is armed and the request source chosen in its control word is active. The sources are an external pin, a timer event, a serial port request, or a software source that is always pending. A per-channel priority bit decides between the two channels at every transfer boundary. The counter ends the run on its own, clearing the arm bit and, if enabled, raising a one-cycle completion pulse. Software may rewrite any register at any time. The new value applies from the next bus cycle onward.

Top module: `dma2_engine`

## Requirements
- R1: After reset all twelve channel registers read zero, `bus_req` is low and `done_irq` is zero.
- R2: `reg_addr[3]` selects the channel and `reg_addr[2:0]` selects the register: 0 source low, 1 source high (bits 19:16), 2 destination low, 3 destination high, 4 count, 5 control. The high parts read back only 4 bits. Indices 6 and 7 read zero and ignore writes.
- R3: A bus cycle keeps `bus_req` high until `bus_ack` is sampled high at a clock edge at least 4 clocks into the cycle. Every transfer is a read cycle (`bus_we`=0) followed by a write cycle (`bus_we`=1), so with `bus_ack` held high a transfer keeps `bus_req` high for exactly 8 clocks.
- R4: Control bit 2 puts the fetch in I/O space and control bit 3 does the same for the deposit; `bus_io` is 1 for I/O and 0 for memory.
- R5: Control bits 5:4 (source) and 7:6 (destination) select 0 hold, 1 increment, 2 decrement. The step is 2 when control bit 1 (word) is set and 1 otherwise. `bus_word` shows the width.
- R6: A byte fetch takes the upper data lane from an odd address and the lower lane from an even one. A byte deposit drives that byte on both lanes.
- R7: A count of N gives N transfers. After the last one, control bit 0 (arm) clears. If control bit 11 is set, `done_irq` for that channel pulses for exactly one clock.
- R8: Control bits 9:8 choose the request source: 0 `ext_req`, 1 `timer_evt`, 2 `serial_req`, 3 software (always pending). Sources that are not chosen have no effect.
- R9: With control bit 10 set on one channel only, that channel wins every transfer boundary where both request, so it preempts a running lower-priority channel after the current transfer.
- R10: When both channels request with equal priority they alternate transfer by transfer, and channel 0 goes first after reset.
- R11: A register write during a run takes effect for the next bus cycle and overrides the pointer step or count decrement of the same clock.
- R12: `bus_addr`, `bus_we` and `bus_io` stay constant for the whole of a bus cycle, even if the registers change meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select and register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ext_req | input | 2 | External request pins, one per channel |
| timer_evt | input | 1 | Timer request shared by both channels |
| serial_req | input | 2 | Serial port requests, one per channel |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 for deposit (write), 0 for fetch (read) |
| bus_io | output | 1 | 1 selects I/O space, 0 memory |
| bus_word | output | 1 | 1 for word width, 0 for byte |
| bus_addr | output | 20 | Bus address |
| bus_wdata | output | 16 | Deposit data |
| bus_rdata | input | 16 | Fetch data |
| bus_ack | input | 1 | Bus ready; ends a cycle once the minimum length is met |
| done_irq | output | 2 | Completion pulse per channel |

## Verification
The hardest case to reach is a higher-priority channel breaking into a run that is already in progress. The other channel must be part way through its count, and the request must arrive close to a transfer boundary. The bench starts a low-priority software-triggered run. It watches the transactions logged at the bus, and raises the high-priority channel's pin right after the first deposit. It then checks that the two high-priority transfers land between the first and second low-priority ones. A register rewrite is reached the same way, timed by the logged bus cycles. So is a source pointer rewrite made while a bus cycle is stretched by holding `bus_ack` low.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FETCH   = 2'd1,
      ST_DEPOSIT = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      TRG_PIN    = 2'd0,
      TRG_TIMER  = 2'd1,
      TRG_SERIAL = 2'd2,
      TRG_SOFT   = 2'd3
   } trig_e;

   // control word, bit 0 is arm
   typedef struct packed {
      logic       irq_en;    // 11
      logic       hi_prio;   // 10
      logic [1:0] trig;      // 9:8
      logic [1:0] dst_mode;  // 7:6
      logic [1:0] src_mode;  // 5:4
      logic       dst_io;    // 3
      logic       src_io;    // 2
      logic       word;      // 1
      logic       arm;       // 0
   } ctrl_t;

   localparam int CTRL_W = 12;

   localparam logic [2:0] IDX_SRC_LO = 3'd0;
   localparam logic [2:0] IDX_SRC_HI = 3'd1;
   localparam logic [2:0] IDX_DST_LO = 3'd2;
   localparam logic [2:0] IDX_DST_HI = 3'd3;
   localparam logic [2:0] IDX_COUNT  = 3'd4;
   localparam logic [2:0] IDX_CTRL   = 3'd5;

endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int CNT_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_idx,
   input  logic [15:0]       wr_data,
   input  logic [2:0]        rd_idx,
   output logic [15:0]       rd_data,
   input  logic              pin_req,
   input  logic              timer_req,
   input  logic              serial_req,
   input  logic              src_step,
   input  logic              xfer_done,
   output logic              req,
   output logic              hi_prio,
   output logic              word,
   output logic              src_io,
   output logic              dst_io,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              irq
);

   localparam int HI_W = ADDR_W - 16;
   localparam logic [CTRL_W-1:0] CTRL_MASK = WORD_EN ? 12'hFFF : 12'hFFD;

   logic [ADDR_W-1:0] src_q, dst_q, delta;
   logic [CNT_W-1:0]  cnt_q;
   ctrl_t             ctrl_q;
   logic              irq_q;
   logic              wr_src_lo, wr_src_hi, wr_dst_lo, wr_dst_hi, wr_cnt, wr_ctrl;
   logic              last;

   assign wr_src_lo = wr_en && (wr_idx == IDX_SRC_LO);
   assign wr_src_hi = wr_en && (wr_idx == IDX_SRC_HI);
   assign wr_dst_lo = wr_en && (wr_idx == IDX_DST_LO);
   assign wr_dst_hi = wr_en && (wr_idx == IDX_DST_HI);
   assign wr_cnt    = wr_en && (wr_idx == IDX_COUNT);
   assign wr_ctrl   = wr_en && (wr_idx == IDX_CTRL);

   assign delta = ctrl_q.word ? ADDR_W'(2) : ADDR_W'(1);
   assign last  = (cnt_q == CNT_W'(1));

   function automatic logic [ADDR_W-1:0] stepped(input logic [ADDR_W-1:0] p,
                                                  input logic [1:0] m);
      case (m)
         2'd1:    return p + delta;
         2'd2:    return p - delta;
         default: return p;
      endcase
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_src_lo || wr_src_hi) begin
            if (wr_src_lo) src_q[15:0]        <= wr_data;
            if (wr_src_hi) src_q[ADDR_W-1:16] <= wr_data[HI_W-1:0];
         end else if (src_step) begin
            src_q <= stepped(src_q, ctrl_q.src_mode);
         end

         if (wr_dst_lo || wr_dst_hi) begin
            if (wr_dst_lo) dst_q[15:0]        <= wr_data;
            if (wr_dst_hi) dst_q[ADDR_W-1:16] <= wr_data[HI_W-1:0];
         end else if (xfer_done) begin
            dst_q <= stepped(dst_q, ctrl_q.dst_mode);
         end

         if (wr_cnt)         cnt_q <= wr_data[CNT_W-1:0];
         else if (xfer_done) cnt_q <= cnt_q - 1'b1;

         if (wr_ctrl)                ctrl_q     <= ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_MASK);
         else if (xfer_done && last) ctrl_q.arm <= 1'b0;

         irq_q <= xfer_done && last && ctrl_q.irq_en;
      end
   end

   always_comb begin
      case (rd_idx)
         IDX_SRC_LO: rd_data = src_q[15:0];
         IDX_SRC_HI: rd_data = 16'(src_q[ADDR_W-1:16]);
         IDX_DST_LO: rd_data = dst_q[15:0];
         IDX_DST_HI: rd_data = 16'(dst_q[ADDR_W-1:16]);
         IDX_COUNT:  rd_data = 16'(cnt_q);
         IDX_CTRL:   rd_data = 16'(ctrl_q);
         default:    rd_data = '0;
      endcase
   end

   logic src_sel;
   always_comb begin
      case (trig_e'(ctrl_q.trig))
         TRG_PIN:    src_sel = pin_req;
         TRG_TIMER:  src_sel = timer_req;
         TRG_SERIAL: src_sel = serial_req;
         default:    src_sel = 1'b1;
      endcase
   end

   assign req      = ctrl_q.arm && src_sel;
   assign hi_prio  = ctrl_q.hi_prio;
   assign word     = ctrl_q.word;
   assign src_io   = ctrl_q.src_io;
   assign dst_io   = ctrl_q.dst_io;
   assign src_addr = src_q;
   assign dst_addr = dst_q;
   assign irq      = irq_q;

   // R7: the final transfer disarms the channel unless software rewrites control
   assert_arm_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && last && !wr_ctrl) |=> !ctrl_q.arm);

   // R7: completion is a single-clock pulse
   assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

endmodule

// File: rtl/dma2_arb.sv
module dma2_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       open,
   input  logic [1:0] req,
   input  logic [1:0] hi,
   output logic [1:0] gnt
);

   logic last_q;   // channel granted most recently

   always_comb begin
      gnt = 2'b00;
      if (open) begin
         if (req == 2'b11) begin
            if (hi[0] != hi[1]) gnt = hi[1] ? 2'b10 : 2'b01;
            else                gnt = last_q ? 2'b01 : 2'b10;
         end else begin
            gnt = req;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        last_q <= 1'b1;
      else if (|gnt)     last_q <= gnt[1];
   end

   // R9: never more than one channel owns a transfer
   assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R10: after an equal-priority tie, the same tie goes the other way next time
   assert_rr_alternate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (open && req == 2'b11 && hi[0] == hi[1] && gnt[0]) |=> (last_q == 1'b0));

   // R9: with both requesting and differing priority, the low one never wins
   assert_prio_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (open && req == 2'b11 && hi == 2'b10) |-> !gnt[0]);

endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
   import dma2_pkg::*;
#(
   parameter int ADDR_W       = 20,
   parameter int DATA_W       = 16,
   parameter int MIN_BUS_CLKS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             gnt,
   input  logic [1:0][ADDR_W-1:0] src_addr,
   input  logic [1:0][ADDR_W-1:0] dst_addr,
   input  logic [1:0]             word,
   input  logic [1:0]             src_io,
   input  logic [1:0]             dst_io,
   output logic                   open,
   output logic [1:0]             src_step,
   output logic [1:0]             xfer_done,
   output logic                   bus_req,
   output logic                   bus_we,
   output logic                   bus_io,
   output logic                   bus_word,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [DATA_W-1:0]      bus_wdata,
   input  logic [DATA_W-1:0]      bus_rdata,
   input  logic                   bus_ack
);

   localparam int CW   = $clog2(MIN_BUS_CLKS + 1);
   localparam int HALF = DATA_W / 2;
   localparam logic [CW-1:0] CYC_LAST = CW'(MIN_BUS_CLKS - 1);

   seq_state_e        state_q;
   logic              ch_q, io_q, word_q;
   logic [CW-1:0]     cyc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, fetched;
   logic              cyc_end;
   logic [HALF-1:0]   lane;

   assign cyc_end = (state_q != ST_IDLE) && bus_ack && (cyc_q == CYC_LAST);
   assign lane    = addr_q[0] ? bus_rdata[DATA_W-1:HALF] : bus_rdata[HALF-1:0];
   assign fetched = word_q ? bus_rdata : {2{lane}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ch_q    <= 1'b0;
         io_q    <= 1'b0;
         word_q  <= 1'b0;
         cyc_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (|gnt) begin
                  ch_q    <= gnt[1];
                  addr_q  <= src_addr[gnt[1]];
                  io_q    <= src_io[gnt[1]];
                  word_q  <= word[gnt[1]];
                  cyc_q   <= '0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (cyc_end) begin
                  data_q  <= fetched;
                  addr_q  <= dst_addr[ch_q];
                  io_q    <= dst_io[ch_q];
                  cyc_q   <= '0;
                  state_q <= ST_DEPOSIT;
               end else if (cyc_q != CYC_LAST) begin
                  cyc_q <= cyc_q + 1'b1;
               end
            end
            ST_DEPOSIT: begin
               if (cyc_end)                state_q <= ST_IDLE;
               else if (cyc_q != CYC_LAST) cyc_q   <= cyc_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign open      = (state_q == ST_IDLE);
   assign src_step  = (state_q == ST_FETCH   && cyc_end) ? {ch_q, ~ch_q} : 2'b00;
   assign xfer_done = (state_q == ST_DEPOSIT && cyc_end) ? {ch_q, ~ch_q} : 2'b00;
   assign bus_req   = (state_q != ST_IDLE);
   assign bus_we    = (state_q == ST_DEPOSIT);
   assign bus_io    = io_q;
   assign bus_word  = word_q;
   assign bus_addr  = addr_q;
   assign bus_wdata = data_q;

   // R3: a bus cycle never drops its request before it completes
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !cyc_end) |=> bus_req);

   // R3: a fetch is always followed by a deposit
   assert_fetch_then_deposit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && cyc_end) |=> (bus_req && bus_we));

   // R12: address and kind of cycle are frozen until the cycle ends
   assert_addr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !cyc_end) |=> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_io)));

endmodule

// File: rtl/dma2_engine.sv
module dma2_engine #(
   parameter int ADDR_W       = 20,
   parameter int CNT_W        = 16,
   parameter int MIN_BUS_CLKS = 4,
   parameter bit WORD_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic [1:0]        ext_req,
   input  logic              timer_evt,
   input  logic [1:0]        serial_req,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_io,
   output logic              bus_word,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ack,
   output logic [1:0]        done_irq
);

   localparam int NUM_CH = 2;

   if (ADDR_W < 17 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dma2_engine: ADDR_W must lie in 17..32");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("dma2_engine: CNT_W must lie in 1..16");
   end
   if (MIN_BUS_CLKS < 1) begin : g_bad_min
      $error("dma2_engine: MIN_BUS_CLKS must be at least 1");
   end

   logic [NUM_CH-1:0][15:0]       rd_ch;
   logic [NUM_CH-1:0][ADDR_W-1:0] src_addr, dst_addr;
   logic [NUM_CH-1:0]             req, hi, word, src_io, dst_io;
   logic [NUM_CH-1:0]             src_step, xfer_done, gnt;
   logic                          open;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma2_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .WORD_EN(WORD_EN)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (reg_we && (reg_addr[3] == 1'(c))),
         .wr_idx    (reg_addr[2:0]),
         .wr_data   (reg_wdata),
         .rd_idx    (reg_addr[2:0]),
         .rd_data   (rd_ch[c]),
         .pin_req   (ext_req[c]),
         .timer_req (timer_evt),
         .serial_req(serial_req[c]),
         .src_step  (src_step[c]),
         .xfer_done (xfer_done[c]),
         .req       (req[c]),
         .hi_prio   (hi[c]),
         .word      (word[c]),
         .src_io    (src_io[c]),
         .dst_io    (dst_io[c]),
         .src_addr  (src_addr[c]),
         .dst_addr  (dst_addr[c]),
         .irq       (done_irq[c])
      );
   end

   assign reg_rdata = rd_ch[reg_addr[3]];

   dma2_arb u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .open (open),
      .req  (req),
      .hi   (hi),
      .gnt  (gnt)
   );

   dma2_seq #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (16),
      .MIN_BUS_CLKS(MIN_BUS_CLKS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt      (gnt),
      .src_addr (src_addr),
      .dst_addr (dst_addr),
      .word     (word),
      .src_io   (src_io),
      .dst_io   (dst_io),
      .open     (open),
      .src_step (src_step),
      .xfer_done(xfer_done),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_io   (bus_io),
      .bus_word (bus_word),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_ack  (bus_ack)
   );

endmodule

// File: tb/sim_dma2_engine.sv
`timescale 1ns/1ps
module sim_dma2_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   wire  [15:0] reg_rdata;
   logic [1:0]  ext_req = '0;
   logic        timer_evt = 1'b0;
   logic [1:0]  serial_req = '0;
   wire         bus_req, bus_we, bus_io, bus_word;
   wire  [19:0] bus_addr;
   wire  [15:0] bus_wdata;
   wire  [15:0] bus_rdata;
   logic        ack_en = 1'b1;
   wire         bus_ack;
   wire  [1:0]  done_irq;

   always #2.5 clk = ~clk;

   // bus slave model: read data is a function of the address
   assign bus_rdata = bus_addr[15:0] ^ 16'h5A3C;
   assign bus_ack   = ack_en;

   dma2_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
      .timer_evt(timer_evt), .serial_req(serial_req), .bus_req(bus_req),
      .bus_we(bus_we), .bus_io(bus_io), .bus_word(bus_word), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .done_irq(done_irq)
   );

   int checks = 0;
   int errors = 0;

   // transaction log from the bus side
   logic [19:0] lg_addr [0:63];
   logic [15:0] lg_data [0:63];
   logic        lg_we   [0:63];
   logic        lg_io   [0:63];
   logic        lg_word [0:63];
   int log_n, cyc_cnt, req_clks, irq0, irq1;

   always @(negedge clk) begin
      if (!rst_n) begin
         log_n = 0; cyc_cnt = 0; req_clks = 0; irq0 = 0; irq1 = 0;
      end else begin
         if (done_irq[0]) irq0++;
         if (done_irq[1]) irq1++;
         if (bus_req) begin
            req_clks++;
            if (bus_ack && cyc_cnt >= 3) begin
               if (log_n < 64) begin
                  lg_addr[log_n] = bus_addr;
                  lg_data[log_n] = bus_wdata;
                  lg_we[log_n]   = bus_we;
                  lg_io[log_n]   = bus_io;
                  lg_word[log_n] = bus_word;
               end
               log_n++;
               cyc_cnt = 0;
            end else begin
               cyc_cnt++;
            end
         end
      end
   end

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mem_rd(input logic [19:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   function automatic logic [15:0] byte_dep(input logic [19:0] a);
      logic [15:0] w = mem_rd(a);
      logic [7:0]  b = a[0] ? w[15:8] : w[7:0];
      return {b, b};
   endfunction

   task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_log(input int n, input int maxc);
      for (int i = 0; i < maxc && log_n < n; i++) @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 1'b0; ext_req = '0; timer_evt = 1'b0; serial_req = '0;
      ack_en = 1'b1; reg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // log entry check helper: one bus cycle
   task automatic chk_entry(input string rq, input int i, input logic we,
                            input logic [19:0] a, input logic io);
      chk(rq, $sformatf("entry %0d we", i), 32'(lg_we[i]), 32'(we));
      chk(rq, $sformatf("entry %0d addr", i), 32'(lg_addr[i]), 32'(a));
      chk(rq, $sformatf("entry %0d io", i), 32'(lg_io[i]), 32'(io));
   endtask

   task automatic t_reset_regs;
      logic [15:0] v;
      do_reset();
      chk("R1", "bus_req", 32'(bus_req), 32'd0);
      chk("R1", "done_irq", 32'(done_irq), 32'd0);
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < 6; i++) begin
            reg_read(4'(c * 8 + i), v);
            chk("R1", $sformatf("reg ch%0d idx%0d", c, i), 32'(v), 32'd0);
         end
      @(negedge clk);
      reg_write(4'd9, 16'hFFFF);
      reg_write(4'd10, 16'h1234);
      reg_write(4'd14, 16'hBEEF);
      reg_read(4'd9, v);  chk("R2", "src hi width", 32'(v), 32'h000F);
      reg_read(4'd10, v); chk("R2", "dst lo readback", 32'(v), 32'h1234);
      reg_read(4'd14, v); chk("R2", "idx 6 reads zero", 32'(v), 32'd0);
      reg_read(4'd1, v);  chk("R2", "ch0 untouched", 32'(v), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_word_copy;
      logic [15:0] v;
      do_reset();
      reg_write(4'd0, 16'h1000); reg_write(4'd1, 16'h0003);
      reg_write(4'd2, 16'h2000); reg_write(4'd3, 16'h0003);
      reg_write(4'd4, 16'd3);
      reg_write(4'd5, 16'h0B53);   // arm, word, inc/inc, software, irq
      wait_log(6, 300);
      repeat (4) @(negedge clk);
      chk("R7", "bus cycles", 32'(log_n), 32'd6);
      for (int i = 0; i < 3; i++) begin
         chk_entry("R3", 2 * i, 1'b0, 20'h31000 + 20'(2 * i), 1'b0);
         chk_entry("R5", 2 * i + 1, 1'b1, 20'h32000 + 20'(2 * i), 1'b0);
         chk("R5", "word flag", 32'(lg_word[2 * i]), 32'd1);
         chk("R3", "deposit data", 32'(lg_data[2 * i + 1]),
             32'(mem_rd(20'h31000 + 20'(2 * i))));
      end
      chk("R3", "req clocks for 3 transfers", 32'(req_clks), 32'd24);
      reg_read(4'd5, v); chk("R7", "arm cleared", 32'(v), 32'h0B52);
      reg_read(4'd4, v); chk("R7", "count zero", 32'(v), 32'd0);
      reg_read(4'd0, v); chk("R5", "src advanced", 32'(v), 32'h1006);
      reg_read(4'd2, v); chk("R5", "dst advanced", 32'(v), 32'h2006);
      chk("R7", "irq pulses", 32'(irq0), 32'd1);
      @(negedge clk);
   endtask

   task automatic t_byte_io;
      logic [15:0] v;
      do_reset();
      reg_write(4'd0, 16'h0011);
      reg_write(4'd2, 16'h0040);
      reg_write(4'd4, 16'd2);
      reg_write(4'd5, 16'h0329);   // arm, byte, dst io, src dec, dst hold, software
      wait_log(4, 200);
      repeat (4) @(negedge clk);
      chk_entry("R5", 0, 1'b0, 20'h00011, 1'b0);
      chk_entry("R4", 1, 1'b1, 20'h00040, 1'b1);
      chk_entry("R5", 2, 1'b0, 20'h00010, 1'b0);
      chk_entry("R4", 3, 1'b1, 20'h00040, 1'b1);
      chk("R5", "byte flag", 32'(lg_word[1]), 32'd0);
      chk("R6", "odd byte lane", 32'(lg_data[1]), 32'(byte_dep(20'h00011)));
      chk("R6", "even byte lane", 32'(lg_data[3]), 32'(byte_dep(20'h00010)));
      reg_read(4'd0, v); chk("R5", "src decremented", 32'(v), 32'h000F);
      chk("R7", "no irq when disabled", 32'(irq0), 32'd0);
      @(negedge clk);
   endtask

   task automatic t_triggers;
      do_reset();
      ext_req = 2'b11;
      reg_write(4'd0, 16'h0100); reg_write(4'd2, 16'h0200);
      reg_write(4'd4, 16'd1);
      reg_write(4'd5, 16'h0101);   // ch0: timer source
      reg_write(4'd8, 16'h0300); reg_write(4'd10, 16'h0400);
      reg_write(4'd12, 16'd1);
      reg_write(4'd13, 16'h0201);  // ch1: serial source
      repeat (30) @(negedge clk);
      chk("R8", "pin ignored when not selected", 32'(log_n), 32'd0);
      timer_evt = 1'b1;
      wait_log(2, 100);
      repeat (30) @(negedge clk);
      chk("R8", "timer starts ch0 only", 32'(log_n), 32'd2);
      chk("R8", "timer fetch addr", 32'(lg_addr[0]), 32'h00100);
      serial_req = 2'b10;
      wait_log(4, 100);
      repeat (4) @(negedge clk);
      chk("R8", "serial starts ch1", 32'(log_n), 32'd4);
      chk("R8", "serial fetch addr", 32'(lg_addr[2]), 32'h00300);
   endtask

   task automatic t_preempt;
      logic [19:0] exp_dst [0:4];
      do_reset();
      reg_write(4'd8, 16'h2000); reg_write(4'd10, 16'h0200);
      reg_write(4'd12, 16'd2);
      reg_write(4'd13, 16'h0453);  // ch1: high priority, pin source, word inc
      reg_write(4'd0, 16'h1000); reg_write(4'd2, 16'h0100);
      reg_write(4'd4, 16'd3);
      reg_write(4'd5, 16'h0353);   // ch0: low priority, software, word inc
      wait_log(2, 200);
      ext_req = 2'b10;
      wait_log(10, 400);
      repeat (4) @(negedge clk);
      exp_dst[0] = 20'h100; exp_dst[1] = 20'h200; exp_dst[2] = 20'h202;
      exp_dst[3] = 20'h102; exp_dst[4] = 20'h104;
      chk("R9", "total cycles", 32'(log_n), 32'd10);
      for (int i = 0; i < 5; i++)
         chk("R9", $sformatf("deposit %0d addr", i), 32'(lg_addr[2 * i + 1]),
             32'(exp_dst[i]));
   endtask

   task automatic t_round_robin;
      do_reset();
      reg_write(4'd2, 16'h0010); reg_write(4'd4, 16'd2);
      reg_write(4'd5, 16'h0001);   // ch0: pin, byte, hold
      reg_write(4'd10, 16'h0020); reg_write(4'd12, 16'd2);
      reg_write(4'd13, 16'h0001);  // ch1: pin, byte, hold
      ext_req = 2'b11;
      wait_log(8, 400);
      repeat (4) @(negedge clk);
      chk("R10", "total cycles", 32'(log_n), 32'd8);
      for (int i = 0; i < 4; i++)
         chk("R10", $sformatf("deposit %0d addr", i), 32'(lg_addr[2 * i + 1]),
             (i % 2 == 0) ? 32'h10 : 32'h20);
   endtask

   task automatic t_rewrite;
      do_reset();
      reg_write(4'd0, 16'h4000); reg_write(4'd2, 16'h0500);
      reg_write(4'd4, 16'd3);
      reg_write(4'd5, 16'h0353);
      wait_log(2, 200);
      reg_write(4'd2, 16'h0800);
      wait_log(6, 300);
      repeat (4) @(negedge clk);
      chk("R11", "first deposit", 32'(lg_addr[1]), 32'h00500);
      chk("R11", "rewritten deposit", 32'(lg_addr[3]), 32'h00800);
      chk("R11", "stepped from new value", 32'(lg_addr[5]), 32'h00802);
      chk("R11", "fetch unaffected", 32'(lg_addr[4]), 32'h04004);
   endtask

   task automatic t_wait_states;
      do_reset();
      ack_en = 1'b0;
      reg_write(4'd0, 16'h0600); reg_write(4'd2, 16'h0700);
      reg_write(4'd4, 16'd1);
      reg_write(4'd5, 16'h0301);
      repeat (20) @(negedge clk);
      chk("R3", "req held without ack", 32'(bus_req), 32'd1);
      chk("R3", "still fetching", 32'(bus_we), 32'd0);
      chk("R3", "no cycle completed", 32'(log_n), 32'd0);
      reg_write(4'd0, 16'h7777);
      @(negedge clk);
      chk("R12", "addr frozen in cycle", 32'(bus_addr), 32'h00600);
      ack_en = 1'b1;
      wait_log(2, 100);
      repeat (4) @(negedge clk);
      chk_entry("R3", 0, 1'b0, 20'h00600, 1'b0);
      chk_entry("R3", 1, 1'b1, 20'h00700, 1'b0);
   endtask

   initial begin
      t_reset_regs();
      t_word_copy();
      t_byte_io();
      t_triggers();
      t_preempt();
      t_round_robin();
      t_rewrite();
      t_wait_states();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule